// File: doc/BRIEF.md
# Local Bus Strobe Timer

This block drives the control strobes for one access on a simple parallel local bus. A requester raises `req` for one cycle with `rnw` and `mode`. The block then starts a cycle counter and lowers and raises each active-low strobe at a cycle count held in a small timing register. The same timing fields serve both signalling styles. The separate-strobe style (`mode`=0) uses chip selects, a read strobe and a write strobe. The direction style (`mode`=1) uses a read-not-write line and data strobes.

The timing register is a 32-bit word. The host bus and the configuration loader can both write it. Each field is captured when an access is accepted. A one-cycle `ack` marks the last cycle of the access. Only then can the block accept a new request.

Top module: `lbus_strobe_timer`

## Requirements
- R1: Timing-word fields use these bit positions: hold-off 15:12, read-on 19:16, read-off 23:20, write-on 27:24, write-off 31:28. Bits 11:0 are ignored. With the default parameters, reset loads hold-off 2, read-on 0, read-off 3, write-on 0 and write-off 2.
- R2: A request is accepted at a clock edge while the block is idle. The cycle after that edge is the reference cycle, count k=0. In separate-strobe mode, a read drives `rd_n` low for read-on <= k < read-off. Both `cs_n` bits are low for k < read-off.
- R3: In separate-strobe mode, a write drives `wr_n` low for write-on <= k < write-off. Both `cs_n` bits are low for k < hold-off.
- R4: In direction mode, both `ds_n` bits are low for the read window on reads and for the write window on writes. `rdwr_n` is low for k < hold-off on writes and stays high on reads.
- R5: All strobes are high out of reset and whenever no access is in progress. Pins that belong to the other mode stay high.
- R6: If an off count is less than or equal to its on count, the strobe stays high for the whole access.
- R7: A field value above 10 acts as 10.
- R8: `ack` is high for exactly one cycle, at k = last. For a read, last is the read-off count. For a write, last is the larger of write-off and hold-off. The block is idle in the next cycle, and `req` during an access is ignored.
- R9: Register writes made during an access do not change that access. They take effect from the next accepted access.
- R10: A write from either port updates the timing word at the next edge. If both ports write in the same cycle, the host word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write enable for the timing word |
| host_wdata | input | 32 | Host timing word |
| load_we | input | 1 | Configuration-load write enable |
| load_wdata | input | 32 | Configuration-load timing word |
| req | input | 1 | Start-access request |
| rnw | input | 1 | 1 read, 0 write |
| mode | input | 1 | 0 separate strobes, 1 direction plus data strobes |
| ack | output | 1 | Last-cycle pulse of an access |
| cs_n | output | 2 | Chip selects, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| rdwr_n | output | 1 | Read-not-write line, low on writes |
| ds_n | output | 2 | Data strobes, active low |

## Verification
Every pin is decoded from registered state without a further register. The pins for count k are therefore valid one time unit after the k-th edge following the accepting edge. `ack` shows up in the same cycle as the pin values for k = last.

The bench samples one time unit after each rising edge. It compares all pins and `ack` against a per-count model on every cycle from k=0 to last, then checks the idle cycle that follows. Register writes land at the next edge, so the bench updates its model of the timing word only once the write edge has passed.

// File: rtl/lbst_pkg.sv
`timescale 1ns/1ps
package lbst_pkg;
  localparam int REG_W       = 32;
  localparam int TIMING_LSB  = 12;
  localparam int FIELD_W     = 4;
  localparam int MAX_CNT     = 10;
  localparam int CNT_W       = $clog2(MAX_CNT + 2);

  typedef logic [FIELD_W-1:0] fld_t;
  typedef logic [CNT_W-1:0]   cnt_t;

  // member order follows the bit order of the timing word, MSB first
  typedef struct packed {
    fld_t wr_off;
    fld_t wr_on;
    fld_t rd_off;
    fld_t rd_on;
    fld_t hold_off;
  } timing_t;

  typedef struct packed {
    cnt_t wr_off;
    cnt_t wr_on;
    cnt_t rd_off;
    cnt_t rd_on;
    cnt_t hold_off;
  } cap_t;

  typedef enum logic {MODE_SEP = 1'b0, MODE_DIR = 1'b1} bus_mode_e;

  function automatic cnt_t clamp_fld(fld_t v);
    if (int'(v) > MAX_CNT) return cnt_t'(MAX_CNT);
    return cnt_t'(v);
  endfunction
endpackage

// File: rtl/lbst_regs.sv
`timescale 1ns/1ps
module lbst_regs
  import lbst_pkg::*;
#(
  parameter int PARPORT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_we,
  input  logic [REG_W-1:0] host_wdata,
  input  logic             load_we,
  input  logic [REG_W-1:0] load_wdata,
  output timing_t          cfg
);
  localparam timing_t RST_VAL = '{
    wr_off:   fld_t'(2),
    wr_on:    fld_t'(PARPORT != 0 ? 1 : 0),
    rd_off:   fld_t'(PARPORT != 0 ? 2 : 3),
    rd_on:    fld_t'(PARPORT != 0 ? 1 : 0),
    hold_off: fld_t'(2)
  };

  logic unused_low;
  assign unused_low = ^{host_wdata[TIMING_LSB-1:0], load_wdata[TIMING_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (rst)          cfg <= RST_VAL;
    else if (host_we) cfg <= timing_t'(host_wdata[REG_W-1:TIMING_LSB]);
    else if (load_we) cfg <= timing_t'(load_wdata[REG_W-1:TIMING_LSB]);
  end

  assert_host_wins_R10: assert property (@(posedge clk) disable iff (rst)
    host_we |=> cfg == timing_t'($past(host_wdata[REG_W-1:TIMING_LSB])));
endmodule

// File: rtl/lbst_seq.sv
`timescale 1ns/1ps
module lbst_seq
  import lbst_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      req,
  input  logic      rnw,
  input  bus_mode_e mode,
  input  timing_t   cfg,
  output logic      busy,
  output logic      ack,
  output cnt_t      cnt,
  output cap_t      cap_q,
  output logic      rnw_q,
  output bus_mode_e mode_q
);
  cap_t cap_n;
  cnt_t last_n, last_q, wr_end;

  always_comb begin
    cap_n.wr_off   = clamp_fld(cfg.wr_off);
    cap_n.wr_on    = clamp_fld(cfg.wr_on);
    cap_n.rd_off   = clamp_fld(cfg.rd_off);
    cap_n.rd_on    = clamp_fld(cfg.rd_on);
    cap_n.hold_off = clamp_fld(cfg.hold_off);
    wr_end = (cap_n.wr_off > cap_n.hold_off) ? cap_n.wr_off : cap_n.hold_off;
    last_n = rnw ? cap_n.rd_off : wr_end;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      last_q <= '0;
      cap_q  <= '0;
      rnw_q  <= 1'b1;
      mode_q <= MODE_SEP;
    end else if (!busy) begin
      if (req) begin
        busy   <= 1'b1;
        cnt    <= '0;
        last_q <= last_n;
        cap_q  <= cap_n;
        rnw_q  <= rnw;
        mode_q <= mode;
      end
    end else if (cnt == last_q) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + cnt_t'(1);
    end
  end

  assign ack = busy && (cnt == last_q);

  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack && !busy);
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> int'(cnt) <= MAX_CNT);
  assert_capture_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(cap_q) && $stable(rnw_q) && $stable(mode_q)));
endmodule

// File: rtl/lbst_window.sv
`timescale 1ns/1ps
module lbst_window
  import lbst_pkg::*;
(
  input  logic en,
  input  cnt_t cnt,
  input  cnt_t on_at,
  input  cnt_t off_at,
  output logic act
);
  assign act = en && (cnt >= on_at) && (cnt < off_at);
endmodule

// File: rtl/lbus_strobe_timer.sv
`timescale 1ns/1ps
module lbus_strobe_timer
  import lbst_pkg::*;
#(
  parameter int PARPORT = 0,
  parameter int CS_NUM  = 2,
  parameter int DS_NUM  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [REG_W-1:0]  host_wdata,
  input  logic              load_we,
  input  logic [REG_W-1:0]  load_wdata,
  input  logic              req,
  input  logic              rnw,
  input  logic              mode,
  output logic              ack,
  output logic [CS_NUM-1:0] cs_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              rdwr_n,
  output logic [DS_NUM-1:0] ds_n
);
  localparam int W_RD  = 0;
  localparam int W_WR  = 1;
  localparam int W_SEL = 2;
  localparam int W_NUM = 3;

  timing_t   cfg;
  logic      busy, rnw_q;
  cnt_t      cnt;
  cap_t      cap_q;
  bus_mode_e mode_q;
  cnt_t      on_at  [W_NUM];
  cnt_t      off_at [W_NUM];
  logic [W_NUM-1:0] act;
  logic      sep, dstrobe;

  lbst_regs #(.PARPORT(PARPORT)) u_regs (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_wdata(host_wdata),
    .load_we(load_we), .load_wdata(load_wdata),
    .cfg(cfg)
  );

  lbst_seq u_seq (
    .clk(clk), .rst(rst), .req(req), .rnw(rnw), .mode(bus_mode_e'(mode)),
    .cfg(cfg), .busy(busy), .ack(ack), .cnt(cnt), .cap_q(cap_q),
    .rnw_q(rnw_q), .mode_q(mode_q)
  );

  always_comb begin
    on_at[W_RD]   = cap_q.rd_on;
    off_at[W_RD]  = cap_q.rd_off;
    on_at[W_WR]   = cap_q.wr_on;
    off_at[W_WR]  = cap_q.wr_off;
    on_at[W_SEL]  = '0;
    off_at[W_SEL] = rnw_q ? cap_q.rd_off : cap_q.hold_off;
  end

  for (genvar i = 0; i < W_NUM; i++) begin : g_win
    lbst_window u_win (
      .en(busy), .cnt(cnt), .on_at(on_at[i]), .off_at(off_at[i]), .act(act[i])
    );
  end

  assign sep     = (mode_q == MODE_SEP);
  assign dstrobe = rnw_q ? act[W_RD] : act[W_WR];

  assign cs_n   = {CS_NUM{~(sep & act[W_SEL])}};
  assign rd_n   = ~(sep & rnw_q & act[W_RD]);
  assign wr_n   = ~(sep & ~rnw_q & act[W_WR]);
  assign rdwr_n = ~(~sep & ~rnw_q & act[W_SEL]);
  assign ds_n   = {DS_NUM{~(~sep & dstrobe)}};

  assert_idle_high_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (&cs_n && rd_n && wr_n && rdwr_n && &ds_n));
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    ack |-> (&cs_n && rd_n && wr_n && rdwr_n && &ds_n));
  assert_one_style_R5: assert property (@(posedge clk) disable iff (rst)
    !(rd_n && wr_n && &cs_n) |-> (rdwr_n && &ds_n));
endmodule

// File: tb/test_lbus_strobe_timer.sv
`timescale 1ns/1ps
module test_lbus_strobe_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0, load_we = 1'b0;
  logic [31:0] host_wdata = '0, load_wdata = '0;
  logic        req = 1'b0, rnw = 1'b1, mode = 1'b0;
  logic        ack, rd_n, wr_n, rdwr_n;
  logic [1:0]  cs_n, ds_n;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [3:0] f_hold, f_ron, f_roff, f_won, f_woff;

  always #2 clk = ~clk;

  lbus_strobe_timer i_lbus_strobe_timer (
    .clk(clk), .rst(rst), .host_we(host_we), .host_wdata(host_wdata),
    .load_we(load_we), .load_wdata(load_wdata), .req(req), .rnw(rnw),
    .mode(mode), .ack(ack), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .rdwr_n(rdwr_n), .ds_n(ds_n)
  );

  function automatic int clampb(logic [3:0] v);
    return (v > 4'd10) ? 10 : int'(v);
  endfunction

  function automatic logic [31:0] mkword(int woff, int won, int roff, int ron, int hold);
    return {woff[3:0], won[3:0], roff[3:0], ron[3:0], hold[3:0], 12'hA5C};
  endfunction

  function automatic void mirror(logic [31:0] w);
    f_woff = w[31:28]; f_won = w[27:24]; f_roff = w[23:20];
    f_ron = w[19:16]; f_hold = w[15:12];
  endfunction

  // {cs_n, rd_n, wr_n, rdwr_n, ds_n}
  function automatic logic [6:0] exp_pins(bit r, bit dir, int k,
                                          int hold, int ron, int roff, int won, int woff);
    bit selw, rw, ww;
    logic [6:0] e;
    selw = k < (r ? roff : hold);
    rw   = (ron <= k) && (k < roff);
    ww   = (won <= k) && (k < woff);
    e[6:5] = (!dir && selw) ? 2'b00 : 2'b11;
    e[4]   = !(!dir && r && rw);
    e[3]   = !(!dir && !r && ww);
    e[2]   = !(dir && !r && selw);
    e[1:0] = (dir && (r ? rw : ww)) ? 2'b00 : 2'b11;
    return e;
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: pins+ack got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic host_write(logic [31:0] w);
    @(negedge clk); host_we = 1'b1; host_wdata = w;
    @(negedge clk); host_we = 1'b0; mirror(w);
  endtask

  task automatic load_write(logic [31:0] w);
    @(negedge clk); load_we = 1'b1; load_wdata = w;
    @(negedge clk); load_we = 1'b0; mirror(w);
  endtask

  task automatic run_access(bit r, bit dir, string tag, bit mid_wr, logic [31:0] mid_word, bit poke);
    int hold, ron, roff, won, woff, last;
    hold = clampb(f_hold); ron = clampb(f_ron); roff = clampb(f_roff);
    won = clampb(f_won); woff = clampb(f_woff);
    last = r ? roff : ((woff > hold) ? woff : hold);
    @(negedge clk); req = 1'b1; rnw = r; mode = dir;
    @(posedge clk); #1 req = 1'b0;
    for (int k = 0; k <= last; k++) begin
      check(tag, {cs_n, rd_n, wr_n, rdwr_n, ds_n, ack},
            {exp_pins(r, dir, k, hold, ron, roff, won, woff), 1'b1 & (k == last)});
      if (k == 0 && mid_wr) begin host_we = 1'b1; host_wdata = mid_word; end
      if (k == 0 && poke) begin req = 1'b1; rnw = ~r; end
      @(posedge clk); #1;
      host_we = 1'b0; req = 1'b0;
    end
    // idle cycle after the access: all high, no ack (R5, R8)
    check({tag, "/idle R5 R8"}, {cs_n, rd_n, wr_n, rdwr_n, ds_n, ack}, 8'b11111110);
    if (mid_wr) mirror(mid_word);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 check("R5 reset", {cs_n, rd_n, wr_n, rdwr_n, ds_n, ack}, 8'b11111110);
    @(negedge clk); rst = 1'b0;
    // R1: reset field values, no writes yet
    mirror(mkword(2, 0, 3, 0, 2));
    run_access(1'b1, 1'b0, "R1 read sep", 1'b0, '0, 1'b0);
    run_access(1'b0, 1'b0, "R1 write sep", 1'b0, '0, 1'b0);
    run_access(1'b1, 1'b1, "R1 read dir", 1'b0, '0, 1'b0);
    // R2, R3, R4 directed
    host_write(mkword(5, 1, 7, 2, 4));
    run_access(1'b1, 1'b0, "R2", 1'b0, '0, 1'b0);
    run_access(1'b0, 1'b0, "R3", 1'b0, '0, 1'b0);
    run_access(1'b1, 1'b1, "R4 read", 1'b0, '0, 1'b0);
    run_access(1'b0, 1'b1, "R4 write", 1'b0, '0, 1'b0);
    host_write(mkword(3, 8, 6, 1, 9));
    run_access(1'b0, 1'b0, "R3 hold longer", 1'b0, '0, 1'b0);
    run_access(1'b0, 1'b1, "R4 hold longer", 1'b0, '0, 1'b0);
    // R6: off not after on
    host_write(mkword(3, 3, 2, 5, 0));
    run_access(1'b1, 1'b0, "R6 read sep", 1'b0, '0, 1'b0);
    run_access(1'b0, 1'b0, "R6 write sep", 1'b0, '0, 1'b0);
    run_access(1'b0, 1'b1, "R6 write dir", 1'b0, '0, 1'b0);
    // R7: reserved values clamp to 10
    host_write(mkword(12, 0, 15, 3, 15));
    run_access(1'b1, 1'b0, "R7 read", 1'b0, '0, 1'b0);
    run_access(1'b0, 1'b1, "R7 write", 1'b0, '0, 1'b0);
    host_write(mkword(14, 11, 13, 12, 1));
    run_access(1'b0, 1'b0, "R7 on clamped", 1'b0, '0, 1'b0);
    // R8: request during access ignored
    host_write(mkword(4, 1, 5, 1, 2));
    run_access(1'b1, 1'b0, "R8 poke", 1'b0, '0, 1'b1);
    run_access(1'b0, 1'b1, "R8 poke", 1'b0, '0, 1'b1);
    // R9: write during access only affects the next one
    run_access(1'b1, 1'b0, "R9 during", 1'b1, mkword(9, 2, 1, 0, 6), 1'b0);
    run_access(1'b1, 1'b0, "R9 after", 1'b0, '0, 1'b0);
    run_access(1'b0, 1'b0, "R9 after", 1'b0, '0, 1'b0);
    // R10: both ports at once, then load port alone
    @(negedge clk);
    host_we = 1'b1; host_wdata = mkword(6, 2, 4, 1, 3);
    load_we = 1'b1; load_wdata = mkword(1, 0, 9, 8, 1);
    @(negedge clk); host_we = 1'b0; load_we = 1'b0; mirror(mkword(6, 2, 4, 1, 3));
    run_access(1'b1, 1'b0, "R10 host wins", 1'b0, '0, 1'b0);
    run_access(1'b0, 1'b0, "R10 host wins", 1'b0, '0, 1'b0);
    load_write(mkword(7, 3, 8, 4, 5));
    run_access(1'b1, 1'b1, "R10 load", 1'b0, '0, 1'b0);
    run_access(1'b0, 1'b0, "R10 load", 1'b0, '0, 1'b0);
    // random mix of fields, modes and directions
    for (int n = 0; n < 80; n++) begin
      logic [31:0] w;
      w = $urandom;
      if ($urandom_range(0, 1) == 0) host_write(w); else load_write(w);
      run_access(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R2 R3 R4 R8 random",
                 1'b0, '0, 1'($urandom_range(0, 3) == 0));
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule